// File: doc/BRIEF.md
# Justified pixel pulse-width modulator

This block drives one output pulse per pixel for a laser print engine. A fast timing clock divides every pixel period into `2**CODE_W` ticks (256 with the default 8-bit code), and a one-cycle pixel strobe marks the last tick of each period. On every strobe the block captures an unsigned width code and two placement controls. The pulse is high for a number of ticks equal to the code, and it sits at the start, the centre or the end of the period.

The captured values pass through two strobe-clocked register stages. The values taken at one strobe therefore shape the period that follows the next strobe, which gives one full pixel period of delay. Width and placement can change on every pixel. The all-ones code forces a pulse that fills the whole period, and a code of zero gives no pulse.

Top module: `pwm_justified`

## Requirements
- R1: Inputs are sampled only in a cycle where `pix_strobe_i` is 1. Input values in any other cycle have no effect on `pulse_o`.
- R2: Values sampled at the strobe that ends period k produce the pulse of period k+2. Tick 0 of a period is the first cycle after a strobe.
- R3: A code of 0 keeps `pulse_o` low for the whole period.
- R4: The all-ones code keeps `pulse_o` high on every tick of the period, whatever the placement inputs are.
- R5: A code N from 1 to `2**CODE_W-2` gives one contiguous high run of exactly N ticks in the period.
- R6: With `edge_place_i`=1 and `side_place_i`=0 (left placement), the pulse starts at tick 0.
- R7: With `edge_place_i`=1 and `side_place_i`=1 (right placement), the pulse ends on the last tick, so it starts at tick `2**CODE_W-N`.
- R8: With `edge_place_i`=0 the pulse is centred and starts at tick floor((`2**CODE_W`-N)/2). `side_place_i` is ignored in this mode.
- R9: The tick counter restarts at 0 in the cycle after a strobe and otherwise advances by one each cycle, wrapping modulo `2**CODE_W`.
- R10: A synchronous reset clears both register stages. `pulse_o` is low while reset is asserted and stays low for the two periods after reset until new data has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pix_strobe_i | input | 1 | High during the last tick of each pixel period |
| code_i | input | CODE_W | Pulse width code, unsigned binary |
| edge_place_i | input | 1 | 0: centred pulse; 1: pulse at one edge of the period |
| side_place_i | input | 1 | Used only when edge_place_i is 1: 0 for left, 1 for right |
| pulse_o | output | 1 | Modulated pulse line |

## Verification
The strobe cycle is where two functions meet. In that cycle the last tick of the current pulse is driven from the second stage, and at the same time the first stage captures new inputs and hands its contents to the second stage. Right-placed and full-width pulses are high on exactly that tick, and the bench changes the code and placement on every period. Each tick-15 sample therefore shows whether the old window was still in force, while the following tick-0 sample shows that the new window has taken over. Between strobes the inputs carry unrelated values, so any capture outside the strobe cycle shows up as a wrong tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        PLACE_CENTRE = 2'd0,
        PLACE_LEFT   = 2'd1,
        PLACE_RIGHT  = 2'd2
    } placement_e;

    // Edge bit 0 always means centred; the side bit only matters at an edge.
    function automatic placement_e place_of(input logic edge_sel, input logic side_sel);
        if (!edge_sel)
            return PLACE_CENTRE;
        else if (side_sel)
            return PLACE_RIGHT;
        else
            return PLACE_LEFT;
    endfunction

endpackage

// File: rtl/pwm_capture.sv
module pwm_capture
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              edge_i,
    input  logic              side_i,
    output logic [CODE_W-1:0] code_o,
    output placement_e        place_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        placement_e        place;
    } capture_t;

    capture_t stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.code  <= '0;
            stage_q.place <= PLACE_CENTRE;
        end else if (strobe_i) begin
            stage_q.code  <= code_i;
            stage_q.place <= place_of(edge_i, side_i);
        end
    end

    assign code_o  = stage_q.code;
    assign place_o = stage_q.place;

endmodule

// File: rtl/pwm_decode.sv
module pwm_decode
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    input  placement_e        place_i,
    output logic [CODE_W:0]   start_o,
    output logic [CODE_W:0]   stop_o,
    output logic              full_o
);

    localparam logic [CODE_W:0] PERIOD = (CODE_W+1)'(1) << CODE_W;

    logic [CODE_W:0] len;
    logic [CODE_W:0] spare;

    assign len   = {1'b0, code_i};
    assign spare = PERIOD - len;

    always_comb begin
        unique case (place_i)
            PLACE_LEFT:  start_o = '0;
            PLACE_RIGHT: start_o = spare;
            default:     start_o = spare >> 1;
        endcase
    end

    assign stop_o = start_o + len;
    assign full_o = &code_i;

endmodule

// File: rtl/pwm_window.sv
module pwm_window #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [CODE_W:0]   start_i,
    input  logic [CODE_W:0]   stop_i,
    input  logic              full_i,
    output logic [CODE_W-1:0] tick_o,
    output logic [CODE_W:0]   win_start_o,
    output logic [CODE_W:0]   win_stop_o,
    output logic              win_full_o,
    output logic              hit_o
);

    typedef struct packed {
        logic [CODE_W:0] start;
        logic [CODE_W:0] stop;
        logic            full;
    } window_t;

    window_t           win_q;
    logic [CODE_W-1:0] tick_q;
    logic [CODE_W:0]   tick_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            tick_q <= '0;
        end else if (strobe_i) begin
            win_q.start <= start_i;
            win_q.stop  <= stop_i;
            win_q.full  <= full_i;
            tick_q      <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign tick_ext    = {1'b0, tick_q};
    assign hit_o       = win_q.full | ((tick_ext >= win_q.start) && (tick_ext < win_q.stop));
    assign tick_o      = tick_q;
    assign win_start_o = win_q.start;
    assign win_stop_o  = win_q.stop;
    assign win_full_o  = win_q.full;

endmodule

// File: rtl/pwm_justified.sv
module pwm_justified
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_strobe_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              edge_place_i,
    input  logic              side_place_i,
    output logic              pulse_o
);

    logic [CODE_W-1:0] cap_code;
    placement_e        cap_place;
    logic [CODE_W:0]   dec_start;
    logic [CODE_W:0]   dec_stop;
    logic              dec_full;
    logic [CODE_W-1:0] tick_q;
    logic [CODE_W:0]   win_start;
    logic [CODE_W:0]   win_stop;
    logic              win_full;
    logic              hit;

    pwm_capture #(.CODE_W(CODE_W)) i_capture (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (pix_strobe_i),
        .code_i   (code_i),
        .edge_i   (edge_place_i),
        .side_i   (side_place_i),
        .code_o   (cap_code),
        .place_o  (cap_place)
    );

    pwm_decode #(.CODE_W(CODE_W)) i_decode (
        .code_i  (cap_code),
        .place_i (cap_place),
        .start_o (dec_start),
        .stop_o  (dec_stop),
        .full_o  (dec_full)
    );

    pwm_window #(.CODE_W(CODE_W)) i_window (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (pix_strobe_i),
        .start_i     (dec_start),
        .stop_i      (dec_stop),
        .full_i      (dec_full),
        .tick_o      (tick_q),
        .win_start_o (win_start),
        .win_stop_o  (win_stop),
        .win_full_o  (win_full),
        .hit_o       (hit)
    );

    assign pulse_o = hit & ~rst;

endmodule

// File: rtl/pwm_justified_chk.sv
module pwm_justified_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input logic              pulse,
    input logic [CODE_W-1:0] tick,
    input logic [CODE_W:0]   win_start,
    input logic [CODE_W:0]   win_stop,
    input logic              win_full
);

    localparam logic [CODE_W:0] PERIOD = (CODE_W+1)'(1) << CODE_W;

    logic [CODE_W:0] high_cnt;
    logic            armed;
    logic [CODE_W:0] want_cnt;

    assign want_cnt = win_full ? PERIOD : (win_stop - win_start);

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (tick == '0)); // R9

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (tick == $past(tick) + 1'b1)); // R9

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        win_full |-> pulse); // R4

    AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (!win_full && (win_start == win_stop)) |-> !pulse); // R3

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pulse); // R10

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
            armed    <= 1'b0;
        end else if (strobe) begin
            if (armed) begin
                AST_WIDTH_COUNT: assert ((high_cnt + {{CODE_W{1'b0}}, pulse}) == want_cnt); // R5
            end
            high_cnt <= '0;
            armed    <= 1'b1;
        end else begin
            high_cnt <= high_cnt + {{CODE_W{1'b0}}, pulse};
        end
    end

endmodule

bind pwm_justified pwm_justified_chk #(.CODE_W(CODE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .strobe    (pix_strobe_i),
    .pulse     (pulse_o),
    .tick      (tick_q),
    .win_start (win_start),
    .win_stop  (win_stop),
    .win_full  (win_full)
);

// File: tb/test_pwm_justified.sv
module test_pwm_justified;

    localparam int W = 4;
    localparam int P = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pix_strobe_i = 1'b0;
    logic [W-1:0] code_i = '0;
    logic         edge_place_i = 1'b0;
    logic         side_place_i = 1'b0;
    logic         pulse_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_justified #(.CODE_W(W)) i_pwm_justified (
        .clk          (clk),
        .rst          (rst),
        .pix_strobe_i (pix_strobe_i),
        .code_i       (code_i),
        .edge_place_i (edge_place_i),
        .side_place_i (side_place_i),
        .pulse_o      (pulse_o)
    );

    // Vector for a period index: code in bits 3:0, edge bit 4, side bit 5.
    function automatic int vec_of(int idx, int mode);
        if (mode == 0) return idx % 64;
        return (idx * 37 + 11) % 64;
    endfunction

    function automatic bit exp_pulse(int code, bit ed, bit sd, int t);
        int start;
        if (code == 0) return 1'b0;
        if (code == P - 1) return 1'b1;
        if (!ed) start = (P - code) / 2;
        else if (sd) start = P - code;
        else start = 0;
        return (t >= start) && (t < start + code);
    endfunction

    task automatic check(bit act, bit exp, string tag, int q, int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s period %0d tick %0d: pulse %b expected %b", tag, q, t, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pix_strobe_i = 1'b0;
        code_i = '1;
        edge_place_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(pulse_o, 1'b0, "R10 low in reset", -1, i);
        end
        rst = 1'b0;
        code_i = '0;
        edge_place_i = 1'b0;
    endtask

    task automatic run(int nper, int mode);
        for (int q = 0; q < nper; q++) begin
            for (int t = 0; t < P; t++) begin
                int  v;
                int  code;
                bit  ed;
                bit  sd;
                bit  e;
                string tag;
                @(negedge clk);
                if (q < 2) begin
                    e = 1'b0;
                    tag = "R10 R2 empty after reset";
                end else begin
                    v = vec_of(q - 2, mode);
                    code = v % 16;
                    ed = v[4];
                    sd = v[5];
                    e = exp_pulse(code, ed, sd, t);
                    if (code == 0) tag = "R3 R2 zero code";
                    else if (code == P - 1) tag = "R4 R2 full code";
                    else if (!ed) tag = "R8 R5 R1 centred";
                    else if (sd) tag = "R7 R5 R1 right";
                    else tag = "R6 R9 R5 left";
                end
                check(pulse_o, e, tag, q, t);
                if (t == P - 1) begin
                    v = vec_of(q, mode);
                    pix_strobe_i = 1'b1;
                    code_i = W'(v % 16);
                    edge_place_i = v[4];
                    side_place_i = v[5];
                end else begin
                    // R1: unrelated values between strobes
                    pix_strobe_i = 1'b0;
                    code_i = W'(q * 5 + t * 3 + 7);
                    edge_place_i = t[0];
                    side_place_i = t[1];
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        run(66, 0);
        do_reset();
        run(66, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule